// File: doc/BRIEF.md
# Sigma-Delta Modulator Loop and Boxcar Decimator

This block is the digital half of a first-order sigma-delta converter. An external RC integrator and a differential input pin, used as the comparator, make up the analog half. On every modulator clock edge the block registers the comparator bit and drives it straight back out as the one-bit feedback to the integrator. The block also counts the ones in that registered stream over a fixed power-of-two window. The count is a first-order sinc (boxcar) decimation filter. At the end of each window the block emits the count as one PCM word with a single-cycle strobe.

The window length is 2^`WIN_LOG2` modulator clocks. With the default of 1024 and a 100 MHz clock, words arrive at about 97.7 kHz. A setting of 512 suits a 50 MHz clock. A window of all ones has a count of 2^N. `WIDEN_OUT` chooses how that count is presented. With 1, the output gets one extra bit and the count is exact. With 0, the output stays N bits wide and the count is clamped to 2^N-1. In neither case does the count wrap to zero.

Control is a two-state machine. `ST_PRIME` is entered on reset and lasts one cycle, while the feedback flop takes its first comparator bit. The transition `PRIME_TO_RUN` is unconditional. `ST_RUN` accumulates on every cycle. It has a single self-transition, `RUN_HOLD`. On that transition the window counter wraps and the word is dumped when the window is complete.

Top module: `sdm_decim_adc`

## Requirements
- R1: While `rst` is sampled high, and in the cycle after it, `fb_out`, `pcm_out` and `pcm_valid` are all 0.
- R2: After every clock edge with `rst` low, `fb_out` equals the `cmp_in` value sampled at that edge.
- R3: The first window consists of the `cmp_in` bits sampled at the first edge with `rst` low and at the 2^N-1 edges that follow. Later windows follow on directly, with no bit skipped or counted twice.
- R4: Each PCM word equals the number of ones among the window's 2^N comparator bits.
- R5: With `WIDEN_OUT`=1, a window of all ones gives 2^N on the N+1 bit output. With `WIDEN_OUT`=0 it gives 2^N-1. The output never exceeds those values.
- R6: `pcm_valid` is high for exactly one cycle per window, and successive pulses are exactly 2^N cycles apart.
- R7: `pcm_out` changes only in a cycle where `pcm_valid` is high, and holds its value between pulses.
- R8: A reset in the middle of a window discards the partial count. Counting restarts from R3's first-window rule.
- R9: After reset is released, the first `pcm_valid` appears 2^N+1 clock edges later, counting the first edge with `rst` low. This is because of the one-cycle `ST_PRIME` state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_in | input | 1 | Comparator bit from the differential input |
| fb_out | output | 1 | Registered feedback bit to the integrator |
| pcm_out | output | WIN_LOG2+WIDEN_OUT | Decimated PCM word |
| pcm_valid | output | 1 | One-cycle strobe marking a new word |

## Verification
The bench builds two copies with `WIN_LOG2`=4, a 16-bit window. One has `WIDEN_OUT`=1 and the other `WIDEN_OUT`=0. Both are fed the same comparator stream. The short window brings within reach the full-scale clamp against the widened count, the exact pulse spacing and the reset mid-window, all within a few hundred cycles. It also allows a long run of contiguous windows that exposes any lost or double-counted bit at a window seam.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
    typedef enum logic {
        ST_PRIME = 1'b0,
        ST_RUN   = 1'b1
    } sdm_state_e;
endpackage

// File: rtl/sdm_feedback_reg.sv
module sdm_feedback_reg (
    input  logic clk,
    input  logic rst,
    input  logic cmp_in,
    output logic fb_q
);
    always_ff @(posedge clk) begin
        if (rst) fb_q <= 1'b0;
        else     fb_q <= cmp_in;
    end
endmodule

// File: rtl/sdm_window_ctr.sv
module sdm_window_ctr #(
    parameter int WIN_LOG2 = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic win_last
);
    logic [WIN_LOG2-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst)     pos_q <= '0;
        else if (en) pos_q <= pos_q + 1'b1;
    end

    assign win_last = (pos_q == {WIN_LOG2{1'b1}});
endmodule

// File: rtl/sdm_ones_accum.sv
module sdm_ones_accum #(
    parameter int WIN_LOG2  = 10,
    parameter int WIDEN_OUT = 1,
    localparam int WORD_W   = WIN_LOG2 + WIDEN_OUT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              bit_in,
    input  logic              dump,
    output logic [WORD_W-1:0] word
);
    logic [WIN_LOG2-1:0] tally_q;
    logic [WIN_LOG2:0]   total;

    // Sum including this cycle's bit; may reach 2^N on the last bit.
    assign total = {1'b0, tally_q} + {{WIN_LOG2{1'b0}}, bit_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            tally_q <= '0;
        end else if (en) begin
            if (dump) tally_q <= '0;
            else      tally_q <= total[WIN_LOG2-1:0];
        end
    end

    generate
        if (WIDEN_OUT != 0) begin : g_wide
            assign word = total;
        end else begin : g_clamp
            assign word = total[WIN_LOG2] ? {WIN_LOG2{1'b1}} : total[WIN_LOG2-1:0];
        end
    endgenerate
endmodule

// File: rtl/sdm_decim_adc.sv
module sdm_decim_adc #(
    parameter int WIN_LOG2  = 10,
    parameter int WIDEN_OUT = 1,
    localparam int PCM_W    = WIN_LOG2 + WIDEN_OUT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_in,
    output logic             fb_out,
    output logic [PCM_W-1:0] pcm_out,
    output logic             pcm_valid
);
    import sdm_pkg::*;

    sdm_state_e       state_q, state_d;
    logic             fb_q;
    logic             acc_en;
    logic             win_last;
    logic             dump;
    logic [PCM_W-1:0] word;

    sdm_feedback_reg u_fb (
        .clk    (clk),
        .rst    (rst),
        .cmp_in (cmp_in),
        .fb_q   (fb_q)
    );

    sdm_window_ctr #(.WIN_LOG2(WIN_LOG2)) u_win (
        .clk      (clk),
        .rst      (rst),
        .en       (acc_en),
        .win_last (win_last)
    );

    sdm_ones_accum #(.WIN_LOG2(WIN_LOG2), .WIDEN_OUT(WIDEN_OUT)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .en     (acc_en),
        .bit_in (fb_q),
        .dump   (dump),
        .word   (word)
    );

    // Next-state and enables
    always_comb begin
        state_d = state_q;
        acc_en  = 1'b0;
        unique case (state_q)
            ST_PRIME: state_d = ST_RUN;          // PRIME_TO_RUN
            ST_RUN: begin
                acc_en  = 1'b1;                  // RUN_HOLD
                state_d = ST_RUN;
            end
            default: state_d = ST_PRIME;
        endcase
    end

    assign dump = acc_en & win_last;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_PRIME;
        else     state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            pcm_out   <= '0;
            pcm_valid <= 1'b0;
        end else begin
            pcm_valid <= dump;
            if (dump) pcm_out <= word;
        end
    end

    assign fb_out = fb_q;
endmodule

// File: rtl/sdm_decim_adc_chk.sv
module sdm_decim_adc_chk #(
    parameter int WIN_LOG2  = 10,
    parameter int WIDEN_OUT = 1,
    localparam int PCM_W    = WIN_LOG2 + WIDEN_OUT,
    localparam int GAP_W    = WIN_LOG2 + 2
) (
    input logic             clk,
    input logic             rst,
    input logic             cmp_in,
    input logic             fb_out,
    input logic [PCM_W-1:0] pcm_out,
    input logic             pcm_valid
);
    localparam logic [PCM_W-1:0] MAX_WORD = (WIDEN_OUT != 0)
        ? PCM_W'(1 << WIN_LOG2) : PCM_W'((1 << WIN_LOG2) - 1);
    localparam logic [GAP_W-1:0] WIN_LEN = GAP_W'(1 << WIN_LOG2);

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;
    logic             started_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q     <= '0;
            seen_q    <= 1'b0;
            started_q <= 1'b0;
        end else begin
            started_q <= 1'b1;
            if (pcm_valid) begin
                gap_q  <= GAP_W'(1);
                seen_q <= 1'b1;
            end else if (gap_q != {GAP_W{1'b1}}) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    a_r2_fb_follows: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (fb_out == $past(cmp_in)));

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |-> (pcm_out <= MAX_WORD));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |=> !pcm_valid);

    a_r6_spacing: assert property (@(posedge clk) disable iff (rst)
        (pcm_valid && seen_q) |-> (gap_q == WIN_LEN));

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (started_q && !pcm_valid) |-> $stable(pcm_out));
endmodule

bind sdm_decim_adc sdm_decim_adc_chk #(
    .WIN_LOG2  (WIN_LOG2),
    .WIDEN_OUT (WIDEN_OUT)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cmp_in    (cmp_in),
    .fb_out    (fb_out),
    .pcm_out   (pcm_out),
    .pcm_valid (pcm_valid)
);

// File: tb/sdm_decim_adc_tb_top.sv
module sdm_decim_adc_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB   = 4;
    localparam int WIN  = 1 << NB;
    localparam int WD_LIMIT = 5000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmp = 1'b0;
    logic fb_w, fb_s;
    logic [NB:0]   pcm_w;
    logic [NB-1:0] pcm_s;
    logic vld_w, vld_s;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdm_decim_adc #(.WIN_LOG2(NB), .WIDEN_OUT(1)) dut_i (
        .clk(clk), .rst(rst), .cmp_in(cmp),
        .fb_out(fb_w), .pcm_out(pcm_w), .pcm_valid(vld_w));

    sdm_decim_adc #(.WIN_LOG2(NB), .WIDEN_OUT(0)) dut_sat_i (
        .clk(clk), .rst(rst), .cmp_in(cmp),
        .fb_out(fb_s), .pcm_out(pcm_s), .pcm_valid(vld_s));

    int n_chk = 0;
    int n_bad = 0;
    int q_w[$];
    int q_s[$];
    int run_ones = 0;
    int run_bits = 0;
    logic prev_rst = 1'b1;
    logic prev_cmp = 1'b0;
    int gap = 0;
    bit seen = 0;
    int since_rel = 0;
    logic last_vld = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    bit done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Monitor: compares outputs produced by the previous edge.
    task automatic monitor();
        int e;
        if (prev_rst) begin
            check(fb_w == 0 && fb_s == 0, "R1 fb", int'(fb_w), 0);
            check(vld_w == 0 && vld_s == 0, "R1 valid", int'(vld_w), 0);
            check(pcm_w == 0 && pcm_s == 0, "R1 pcm", int'(pcm_w), 0);
            gap = 0; seen = 0; since_rel = 0; last_vld = 0;
            return;
        end
        since_rel++;
        gap++;
        check(fb_w == prev_cmp && fb_s == prev_cmp, "R2 feedback", int'(fb_w), int'(prev_cmp));
        check(vld_w == vld_s, "R6 valid agree", int'(vld_s), int'(vld_w));
        if (vld_w) begin
            check(!last_vld, "R6 single cycle", 1, 0);
            if (seen) check(gap == WIN, "R6 spacing", gap, WIN);
            else      check(since_rel == WIN + 1, "R9 first word", since_rel, WIN + 1);
            seen = 1; gap = 0;
            if (q_w.size() == 0) begin
                check(0, "R3 unexpected word", int'(pcm_w), -1);
            end else begin
                e = q_w.pop_front();
                check(int'(pcm_w) == e, (e == WIN) ? "R5 widened" : "R4 count", int'(pcm_w), e);
                e = q_s.pop_front();
                check(int'(pcm_s) == e, (e == WIN - 1) ? "R5 clamp" : "R4 count", int'(pcm_s), e);
            end
        end
        last_vld = vld_w;
    endtask

    // Driver: one cycle of stimulus, expected words into the queues.
    task automatic step(input logic r, input logic c);
        @(negedge clk);
        monitor();
        prev_rst = r;
        prev_cmp = c;
        rst = r;
        cmp = c;
        if (r) begin
            run_ones = 0;
            run_bits = 0;
        end else begin
            run_ones += int'(c);
            run_bits++;
            if (run_bits == WIN) begin
                q_w.push_back(run_ones);
                q_s.push_back((run_ones > WIN - 1) ? WIN - 1 : run_ones);
                run_ones = 0;
                run_bits = 0;
            end
        end
    endtask

    task automatic window_const(input logic c);
        for (int i = 0; i < WIN; i++) step(1'b0, c);
    endtask

    task automatic rnd_bit(output logic b);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        b = lfsr[0];
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > WD_LIMIT) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, WD_LIMIT);
                finish_run();
            end
        end
    end

    initial begin
        logic b;
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1);     // R1 reset hold
        window_const(1'b0);                                // R4 zero
        window_const(1'b1);                                // R5 full scale
        for (int i = 0; i < WIN; i++) step(1'b0, logic'(i % 2));   // R4 half
        for (int i = 0; i < WIN; i++) step(1'b0, logic'(i != 5));  // R4 one below full
        for (int i = 0; i < WIN; i++) step(1'b0, logic'(i == WIN - 1)); // R3 seam bit
        for (int i = 0; i < WIN; i++) step(1'b0, logic'(i == 0));       // R3 seam bit
        for (int i = 0; i < 6 * WIN; i++) begin            // R3 contiguous random
            rnd_bit(b);
            step(1'b0, b);
        end
        for (int i = 0; i < 7; i++) step(1'b0, 1'b1);      // R8 partial window
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1);      // R8 reset mid-window
        window_const(1'b1);                                // R8 / R9 restart
        for (int i = 0; i < 3 * WIN; i++) begin
            rnd_bit(b);
            step(1'b0, b | lfsr[3]);
        end
        for (int i = 0; i < WIN + 4; i++) step(1'b0, 1'b0); // flush
        check(q_w.size() == 0, "R3 words outstanding", q_w.size(), 0);
        check(vld_w == 0 && pcm_w == 0, "R7 hold after last word", int'(pcm_w), 0);
        finish_run();
    end
endmodule